// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-byte read and write requests from inside the chip into cycles on an external parallel memory bus. The low address byte and the data byte share one 8-bit bus. A latch-enable strobe marks the address phase so that an outside latch can capture the low address byte. The high address byte has its own output port.

The external address space is split at a programmable boundary on the high address byte into a lower and an upper sector. Each sector has its own 2-bit wait code, which sets how long the strobe stays active and whether the address is held for one extra period at the end. The requester uses a plain handshake. A request is taken only while `busy` is low. `done` pulses once in the last period of the access, and the result of a read appears on `rd_data`.

The shared bus has an optional keeper. When the keeper is enabled, the bus shows its last value while nothing drives it. When it is disabled, the bus floats. The bus is modelled as separate output, enable, keeper and input pins.

Top module: `xbus_ctrl`

## Requirements
- R1: In the first period of an access, `ext_ale` is 1, `ext_ad_oe` is 1, `ext_ad_out` carries address bits 7:0, `ext_ahi` carries address bits 15:8, and both strobes are high.
- R2: Wait code 00 gives an access of 4 periods with 1 strobe period. Code 01 gives 5 periods with 2 strobe periods. Code 10 gives 6 periods with 3 strobe periods. Code 11 gives 7 periods with 3 strobe periods, and its last period keeps the strobes high while `ext_ahi` still shows the address. The strobe periods always start in the third period.
- R3: An access whose address bits 15:8 are greater than or equal to `cfg_boundary` uses `cfg_hi_wait`. Any other access uses `cfg_lo_wait`. The code is taken when the request is accepted.
- R4: In a write, the bus drives the write data from the second period up to and including the period after the last strobe period. `ext_wr_n` is low only in the strobe periods, so the data is on the bus one period before the strobe falls.
- R5: In a read, the bus is released after the first period and `ext_rd_n` is low in the strobe periods. `ext_ad_in` is sampled at the clock edge that ends the last strobe period, and that byte is shown on `rd_data` in the final period and held after it.
- R6: `busy` is 1 in every period of an access. `done` is 1 only in the final period.
- R7: In the final period, `ext_ale` is 1 exactly when `next_is_ram` is 1.
- R8: A request is accepted at a rising edge where `req_valid` is 1 and `busy` is 0. A request presented while `busy` is 1 has no effect on the access in progress.
- R9: `ext_wr_n` and `ext_rd_n` are never low together. While idle, both strobes are high, `ext_ale` is 0, `ext_ad_oe` is 0 and `ext_ahi` is 0.
- R10: While `ext_ad_oe` is 0, `ext_ad_keep` equals `cfg_keeper`. With the keeper on, `ext_ad_out` shows the last byte on the bus: the last byte driven, or the last byte read.
- R11: After reset, `busy`, `done`, `ext_ale` and `ext_ad_oe` are 0 and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| next_is_ram | input | 1 | The following access targets RAM |
| cfg_lo_wait | input | 2 | Wait code for the lower sector |
| cfg_hi_wait | input | 2 | Wait code for the upper sector |
| cfg_boundary | input | 8 | First high-address byte of the upper sector |
| cfg_keeper | input | 1 | Bus keeper enable |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse in the final period |
| rd_data | output | 8 | Byte returned by the last read |
| ext_ale | output | 1 | Address latch enable |
| ext_ahi | output | 8 | High address byte |
| ext_ad_out | output | 8 | Value on the shared address/data bus |
| ext_ad_oe | output | 1 | Strong drive enable of the shared bus |
| ext_ad_keep | output | 1 | Keeper holds the shared bus |
| ext_ad_in | input | 8 | Shared bus input |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |

## Verification
The assertions check ordering rules on every cycle: the two strobes never overlap, the latch pulse never meets an active strobe, write data is on the bus before the write strobe falls, `done` lasts one cycle, the idle bus is quiet, and the keeper holds the bus steady. Exact period counts for each wait code, the sector choice at the boundary, the sampling edge for read data and the trailing latch pulse are checked only by the bench. Its reference model predicts every output in every period of accesses that cover all four codes in both sectors.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STRB, PH_LAST, PH_HOLD
  } phase_e;

  // number of strobe periods beyond the first one
  function automatic logic [1:0] extra_waits(input logic [1:0] code);
    return (code == 2'b00) ? 2'd0 : (code == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  // trailing address-hold period after the strobe
  function automatic logic hold_after(input logic [1:0] code);
    return code == 2'b11;
  endfunction

  // total periods of one access
  function automatic logic [3:0] access_periods(input logic [1:0] code);
    return 4'd4 + {2'b00, extra_waits(code)} + {3'b000, hold_after(code)};
  endfunction

endpackage

// File: rtl/xbus_sector_dec.sv
module xbus_sector_dec #(
  parameter int HW = 8
) (
  input  logic [HW-1:0] addr_hi,
  input  logic [HW-1:0] boundary,
  input  logic [1:0]    lo_code,
  input  logic [1:0]    hi_code,
  output logic [1:0]    code
);
  logic upper;
  assign upper = addr_hi >= boundary;
  assign code  = upper ? hi_code : lo_code;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] wcode,
  output phase_e     phase,
  output logic       final_p,
  output logic       sample_p
);
  phase_e     ph_q;
  logic [1:0] cnt_q;
  logic       hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q   <= PH_ADDR;
          cnt_q  <= extra_waits(wcode);
          hold_q <= hold_after(wcode);
        end
        PH_ADDR:  ph_q <= PH_SETUP;
        PH_SETUP: ph_q <= PH_STRB;
        PH_STRB:  if (cnt_q == 2'd0) ph_q <= PH_LAST;
                  else cnt_q <= cnt_q - 2'd1;
        PH_LAST:  ph_q <= hold_q ? PH_HOLD : PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = ph_q;
  assign final_p  = (ph_q == PH_LAST && !hold_q) || ph_q == PH_HOLD;
  assign sample_p = ph_q == PH_STRB && cnt_q == 2'd0;

  // R2
  hold_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_HOLD |-> $past(ph_q) == PH_LAST);

  // R2
  strb_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph_q) == PH_SETUP |-> ph_q == PH_STRB);
endmodule

// File: rtl/xbus_ad_path.sv
module xbus_ad_path
  import xbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          is_wr,
  input  logic [DW-1:0] addr_lo,
  input  logic [DW-1:0] wdata,
  input  logic          sample,
  input  logic [DW-1:0] ad_in,
  input  logic          keeper_en,
  output logic [DW-1:0] ad_out,
  output logic          oe,
  output logic          keep,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] kept_q;
  logic [DW-1:0] drive_val;
  logic          rd_sample;
  logic          wr_phase;

  assign wr_phase  = phase == PH_SETUP || phase == PH_STRB || phase == PH_LAST;
  assign oe        = phase == PH_ADDR || (is_wr && wr_phase);
  assign drive_val = (phase == PH_ADDR) ? addr_lo : wdata;
  assign rd_sample = sample && !is_wr;
  assign ad_out    = oe ? drive_val : kept_q;
  assign keep      = keeper_en && !oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_q  <= '0;
      rd_data <= '0;
    end else begin
      if (oe)             kept_q <= drive_val;
      else if (rd_sample) kept_q <= ad_in;
      if (rd_sample)      rd_data <= ad_in;
    end
  end

  // R10
  keeper_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep && $past(keep) && !$past(rd_sample) |-> $stable(ad_out));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          next_is_ram,
  input  logic [1:0]    cfg_lo_wait,
  input  logic [1:0]    cfg_hi_wait,
  input  logic [AW-DW-1:0] cfg_boundary,
  input  logic          cfg_keeper,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          ext_ale,
  output logic [AW-DW-1:0] ext_ahi,
  output logic [DW-1:0] ext_ad_out,
  output logic          ext_ad_oe,
  output logic          ext_ad_keep,
  input  logic [DW-1:0] ext_ad_in,
  output logic          ext_wr_n,
  output logic          ext_rd_n
);
  localparam int HW = AW - DW;

  phase_e        phase;
  logic          final_p, sample_p, accept, strobe_p;
  logic [1:0]    wcode;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;

  assign busy   = phase != PH_IDLE;
  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  xbus_sector_dec #(.HW(HW)) u_dec (
    .addr_hi (req_addr[AW-1:DW]),
    .boundary(cfg_boundary),
    .lo_code (cfg_lo_wait),
    .hi_code (cfg_hi_wait),
    .code    (wcode)
  );

  xbus_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .wcode   (wcode),
    .phase   (phase),
    .final_p (final_p),
    .sample_p(sample_p)
  );

  xbus_ad_path #(.DW(DW)) u_ad (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .is_wr    (wr_q),
    .addr_lo  (addr_q[DW-1:0]),
    .wdata    (wdata_q),
    .sample   (sample_p),
    .ad_in    (ext_ad_in),
    .keeper_en(cfg_keeper),
    .ad_out   (ext_ad_out),
    .oe       (ext_ad_oe),
    .keep     (ext_ad_keep),
    .rd_data  (rd_data)
  );

  assign strobe_p = phase == PH_STRB;
  assign ext_wr_n = !(strobe_p && wr_q);
  assign ext_rd_n = !(strobe_p && !wr_q);
  assign ext_ale  = phase == PH_ADDR || (final_p && next_is_ram);
  assign ext_ahi  = busy ? addr_q[AW-1:DW] : '0;
  assign done     = final_p;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_wr_n && !ext_rd_n));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  ale_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> ext_wr_n && ext_rd_n);

  // R4
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_wr_n) |-> $past(ext_ad_oe));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ext_wr_n && ext_rd_n && !ext_ad_oe);

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, next_is_ram = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, cfg_boundary = 8'h80, ext_ad_in = '0;
  logic [1:0] cfg_lo_wait = '0, cfg_hi_wait = '0;
  logic       cfg_keeper = 1'b0;
  logic       busy, done, ext_ale, ext_ad_oe, ext_ad_keep, ext_wr_n, ext_rd_n;
  logic [7:0] rd_data, ext_ahi, ext_ad_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .next_is_ram(next_is_ram),
    .cfg_lo_wait(cfg_lo_wait), .cfg_hi_wait(cfg_hi_wait),
    .cfg_boundary(cfg_boundary), .cfg_keeper(cfg_keeper),
    .busy(busy), .done(done), .rd_data(rd_data), .ext_ale(ext_ale),
    .ext_ahi(ext_ahi), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe),
    .ext_ad_keep(ext_ad_keep), .ext_ad_in(ext_ad_in),
    .ext_wr_n(ext_wr_n), .ext_rd_n(ext_rd_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: one access, checked period by period at falling edges.
  task automatic run_access(input bit wr, input logic [15:0] addr,
                            input logic [7:0] data, input bit nr,
                            input bit keeper);
    int code, extra, hd, len;
    logic [7:0] rd_val;
    bit strobe;
    code  = (addr[15:8] >= cfg_boundary) ? int'(cfg_hi_wait) : int'(cfg_lo_wait);
    extra = (code == 0) ? 0 : (code == 1) ? 1 : 2;
    hd    = (code == 3) ? 1 : 0;
    len   = 4 + extra + hd;
    rd_val = data ^ 8'h5A;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    next_is_ram = nr; cfg_keeper = keeper; ext_ad_in = 8'h00;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      strobe = (k >= 2) && (k <= 2 + extra);
      chk("R6 busy", busy, 1);
      chk("R6 done", done, int'(k == len - 1));
      chk("R8 ahi held", ext_ahi, addr[15:8]);
      chk("R2 R4 wr_n", ext_wr_n, int'(!(wr && strobe)));
      chk("R2 R5 rd_n", ext_rd_n, int'(!(!wr && strobe)));
      if (k == 0) begin
        chk("R1 ale", ext_ale, 1);
        chk("R1 oe", ext_ad_oe, 1);
        chk("R1 addr lo", ext_ad_out, addr[7:0]);
        // R8: present another request while busy
        req_addr = 16'hFFFF; req_wdata = 8'hEE; req_write = ~wr;
      end else begin
        chk("R7 trailing ale", ext_ale, int'(k == len - 1 && nr));
        chk("R4 R5 oe", ext_ad_oe, int'(wr && k <= 3 + extra));
        if (wr && k <= 3 + extra) chk("R4 wdata", ext_ad_out, data);
        if (!ext_ad_oe) chk("R10 keep", ext_ad_keep, int'(keeper));
      end
      if (k == len - 1) begin
        req_valid = 1'b0;
        if (!wr) chk("R5 rd_data", rd_data, rd_val);
      end
      if (k == 2 + extra) ext_ad_in = rd_val;
      if (k == 3 + extra) ext_ad_in = ~rd_val;
    end
    @(negedge clk);
    chk("R9 idle busy", busy, 0);
    chk("R9 idle ale", ext_ale, 0);
    chk("R9 idle strobes", {ext_wr_n, ext_rd_n}, 2'b11);
    chk("R9 idle ahi", ext_ahi, 0);
    chk("R10 idle keep", ext_ad_keep, int'(keeper));
    if (keeper) chk("R10 kept value", ext_ad_out, wr ? data : rd_val);
    if (!wr) chk("R5 rd_data held", rd_data, rd_val);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 ale", ext_ale, 0);
    chk("R11 oe", ext_ad_oe, 0);
    chk("R11 strobes", {ext_wr_n, ext_rd_n}, 2'b11);
    rst_n = 1'b1;
    // R2 R3: all codes, both sectors, both directions
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 4; w++) begin
        for (int d = 0; d < 2; d++) begin
          if (s == 1) begin cfg_hi_wait = 2'(w); cfg_lo_wait = 2'(3 - w); end
          else        begin cfg_lo_wait = 2'(w); cfg_hi_wait = 2'(3 - w); end
          run_access(bit'(d), s ? {8'hA0 + 8'(w), 8'h3C} : {8'h10 + 8'(w), 8'hC3},
                     8'h11 * 8'(w + 1) + 8'(s), bit'((w + d) & 1), bit'((w + s) & 1));
        end
      end
    end
    // R3: boundary edges
    cfg_lo_wait = 2'b00; cfg_hi_wait = 2'b11;
    run_access(1'b0, 16'h8000, 8'h9C, 1'b1, 1'b1);
    run_access(1'b1, 16'h7FFF, 8'h3D, 1'b0, 1'b1);
    cfg_boundary = 8'h00;
    run_access(1'b0, 16'h0001, 8'h47, 1'b0, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule